// File: doc/BRIEF.md
# Fair-Queuing DRAM Request Arbiter

This block chooses, in each cycle, at most one command to issue from a shared transaction buffer that several hardware threads fill. Every buffer slot presents a valid bit, a target bank, a command class (row command or column command), a ready flag from an external timing checker, an arrival timestamp and a virtual finish-time deadline. The deadline is computed upstream from each thread's bandwidth share. Per-bank inputs report whether each bank holds an open row and for how many cycles it has been open. The grant index and grant-valid flag depend combinationally on the current inputs and on a small per-bank commitment state. The requester clears the granted slot on the next cycle.

A mode input picks the ordering. In baseline mode the block gives priority to column commands and then to the oldest arrival. In fair-queuing mode it serves the earliest deadline among the ready slots. It also bounds priority inversion: once a bank has been open for at least the row-active time, the bank is committed to its earliest-deadline request. No other command for that bank is granted until that request becomes ready and is granted.

Top module: `fq_dram_arbiter`

## Requirements
- R1: `grant_valid` is high only when some slot is both valid and ready, and the granted slot is always valid and ready. With no valid-and-ready slot, `grant_valid` is low in the same cycle, and this includes the cycles spent in reset.
- R2: In baseline mode (`fq_mode`=0), a ready column command (`ent_col` bit = 1) is always granted ahead of any ready row command (`ent_col` bit = 0).
- R3: In baseline mode, among ready slots of the same class the one with the smallest arrival value wins. Equal arrivals go to the lowest slot index.
- R4: In fair-queuing mode (`fq_mode`=1), the ready slot with the smallest deadline wins, whatever its class or arrival. Equal deadlines go to the lowest slot index.
- R5: In fair-queuing mode, a bank that is closed, or that has been open for fewer than `TRAS` cycles (default 18), applies plain first-ready earliest-deadline order. A ready slot for that bank can be granted even when an earlier-deadline slot for the same bank is not ready.
- R6: In fair-queuing mode, a bank that has been open for `TRAS` or more cycles grants only its committed slot, which is its earliest-deadline valid slot. Other ready slots for that bank wait until the committed slot is granted. Slots for other banks are not affected.
- R7: A commitment stays on its slot until that slot is granted, even if a slot with an earlier deadline for the same bank arrives in the meantime.
- R8: In baseline mode the open-time of a bank has no effect on which slot is granted.
- R9: A commitment is dropped when its bank stops meeting the lock condition (closed, or mode switched). When the bank locks again, the commitment is taken afresh from the earliest-deadline valid slot at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fq_mode | input | 1 | 1 = fair-queuing deadline order, 0 = baseline order |
| ent_valid | input | N | Slot holds a pending command |
| ent_ready | input | N | Slot command meets all timing constraints now |
| ent_col | input | N | 1 = column (read/write) command, 0 = row command |
| ent_bank | input | N*BW | Target bank per slot |
| ent_arrival | input | N*32 | Arrival timestamp per slot |
| ent_deadline | input | N*32 | Virtual finish-time deadline per slot |
| bank_open | input | NB | Bank has an open row |
| bank_open_cycles | input | NB*CW | Cycles since the bank was activated (saturating) |
| grant_valid | output | 1 | A slot is granted this cycle |
| grant_idx | output | IW | Index of the granted slot |

## Verification
A commitment that is held too long, or taken on the wrong slot, shows up at the grant ports as a locked bank that grants nothing, or that grants a slot other than its earliest-deadline one. Because the grant is combinational, this is visible in the same cycle the inputs change. A stale commitment left over after a bank closes only appears when the bank locks again, on the first cycle of the new lock, so the tests reopen a bank after closing it. Errors in the key ordering appear directly as a wrong `grant_idx` on the cycle the contending slots are presented.

// File: rtl/fqa_pkg.sv
package fqa_pkg;
  localparam int TS_W  = 32;
  localparam int KEY_W = TS_W + 1;

  // Ordering key for the final pick: smaller wins.
  function automatic logic [KEY_W-1:0] arb_key(input logic fq, input logic col,
                                               input logic [TS_W-1:0] arrival,
                                               input logic [TS_W-1:0] deadline);
    if (fq) arb_key = {1'b0, deadline};
    else    arb_key = {~col, arrival};
  endfunction

  // Key used to choose a bank's commitment target.
  function automatic logic [KEY_W-1:0] commit_key(input logic [TS_W-1:0] deadline);
    commit_key = {1'b0, deadline};
  endfunction

  // Bank lock condition for inversion bounding.
  function automatic logic bank_locks(input logic fq, input logic open,
                                      input int unsigned open_cycles,
                                      input int unsigned tras);
    bank_locks = fq && open && (open_cycles >= tras);
  endfunction
endpackage

// File: rtl/fqa_min_select.sv
module fqa_min_select #(
  parameter int N     = 32,
  parameter int KEY_W = 33,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       mask,
  input  logic [N*KEY_W-1:0] keys,
  output logic               found,
  output logic [IW-1:0]      idx
);
  logic [KEY_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (!found || (keys[i*KEY_W +: KEY_W] < best))) begin
        found = 1'b1;
        best  = keys[i*KEY_W +: KEY_W];
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fqa_bank_lock.sv
module fqa_bank_lock #(
  parameter int N   = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          locked,
  input  logic          cand_found,
  input  logic [IW-1:0] cand_idx,
  input  logic [N-1:0]  ent_valid,
  input  logic          grant_valid,
  input  logic [IW-1:0] grant_idx,
  output logic          tgt_valid,
  output logic [IW-1:0] tgt_idx
);
  logic          held_v;
  logic [IW-1:0] held_idx;
  logic          held_live;
  logic          tgt_granted;

  assign held_live   = held_v && ent_valid[held_idx];
  assign tgt_valid   = locked && (held_live || cand_found);
  assign tgt_idx     = held_live ? held_idx : cand_idx;
  assign tgt_granted = tgt_valid && grant_valid && (grant_idx == tgt_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v   <= 1'b0;
      held_idx <= '0;
    end else if (!locked || tgt_granted) begin
      held_v <= 1'b0;
    end else if (!held_live) begin
      held_v   <= cand_found;
      held_idx <= cand_idx;
    end
  end

  // A target exists only while the bank is locked.
  assert_target_needs_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> locked);

  // Commitment does not move while it stays live and ungranted.
  assert_commit_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_granted) |=>
      (!locked || !ent_valid[$past(tgt_idx)] || (tgt_idx == $past(tgt_idx))));
endmodule

// File: rtl/fq_dram_arbiter.sv
module fq_dram_arbiter #(
  parameter int N    = 32,
  parameter int NB   = 8,
  parameter int CW   = 8,
  parameter int TRAS = 18,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int TW  = fqa_pkg::TS_W,
  localparam int KW  = fqa_pkg::KEY_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fq_mode,
  input  logic [N-1:0]   ent_valid,
  input  logic [N-1:0]   ent_ready,
  input  logic [N-1:0]   ent_col,
  input  logic [N*BW-1:0] ent_bank,
  input  logic [N*TW-1:0] ent_arrival,
  input  logic [N*TW-1:0] ent_deadline,
  input  logic [NB-1:0]  bank_open,
  input  logic [NB*CW-1:0] bank_open_cycles,
  output logic           grant_valid,
  output logic [IW-1:0]  grant_idx
);
  import fqa_pkg::*;

  logic [NB-1:0]         bank_locked;
  logic [NB-1:0]         tgt_valid;
  logic [NB-1:0][IW-1:0] tgt_idx;
  logic [NB-1:0]         cand_found;
  logic [NB-1:0][IW-1:0] cand_idx;
  logic [N*KW-1:0]       ckeys;
  logic [N*KW-1:0]       gkeys;
  logic [N-1:0]          eligible;
  logic [NB-1:0][N-1:0]  bank_mask;
  logic                  any_ready_col;
  logic [BW-1:0]         grant_bank;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      ckeys[e*KW +: KW] = commit_key(ent_deadline[e*TW +: TW]);
      gkeys[e*KW +: KW] = arb_key(fq_mode, ent_col[e], ent_arrival[e*TW +: TW],
                                  ent_deadline[e*TW +: TW]);
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < N; e++)
        bank_mask[b][e] = ent_valid[e] && (ent_bank[e*BW +: BW] == BW'(b));
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_locked[b] = bank_locks(fq_mode, bank_open[b],
                                       int'(unsigned'(bank_open_cycles[b*CW +: CW])),
                                       TRAS);

    fqa_min_select #(.N(N), .KEY_W(KW)) u_earliest (
      .mask  (bank_mask[b]),
      .keys  (ckeys),
      .found (cand_found[b]),
      .idx   (cand_idx[b])
    );

    fqa_bank_lock #(.N(N)) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .locked      (bank_locked[b]),
      .cand_found  (cand_found[b]),
      .cand_idx    (cand_idx[b]),
      .ent_valid   (ent_valid),
      .grant_valid (grant_valid),
      .grant_idx   (grant_idx),
      .tgt_valid   (tgt_valid[b]),
      .tgt_idx     (tgt_idx[b])
    );
  end

  always_comb begin
    for (int e = 0; e < N; e++) begin
      logic [BW-1:0] bk;
      bk = ent_bank[e*BW +: BW];
      eligible[e] = ent_valid[e] && ent_ready[e] &&
                    (!bank_locked[bk] || (tgt_valid[bk] && tgt_idx[bk] == IW'(e)));
    end
  end

  fqa_min_select #(.N(N), .KEY_W(KW)) u_grant (
    .mask  (eligible),
    .keys  (gkeys),
    .found (grant_valid),
    .idx   (grant_idx)
  );

  assign any_ready_col = |(ent_valid & ent_ready & ent_col);
  assign grant_bank    = ent_bank[grant_idx*BW +: BW];

  assert_grant_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (ent_valid[grant_idx] && ent_ready[grant_idx]));

  assert_idle_no_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ent_valid & ent_ready)) |-> !grant_valid);

  assert_col_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fq_mode && grant_valid && any_ready_col) |-> ent_col[grant_idx]);

  assert_locked_grants_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && bank_locked[grant_bank]) |->
      (tgt_valid[grant_bank] && tgt_idx[grant_bank] == grant_idx));

  assert_baseline_no_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fq_mode |-> (bank_locked == '0));
endmodule

// File: tb/fq_dram_arbiter_tb_top.sv
`timescale 1ns/1ps
module fq_dram_arbiter_tb_top;
  localparam int N = 32, NB = 8, CW = 8, TRAS = 18;
  localparam int IW = 5, BW = 3;

  logic clk = 0, rst_n = 0, fq_mode = 0;
  logic [N-1:0] vld, rdy, col;
  logic [BW-1:0] bnk [N];
  logic [31:0] arr [N];
  logic [31:0] dl [N];
  logic [NB-1:0] opn;
  logic [CW-1:0] cyc [NB];
  logic [N*BW-1:0] bank_flat;
  logic [N*32-1:0] arr_flat, dl_flat;
  logic [NB*CW-1:0] cyc_flat;
  logic grant_valid;
  logic [IW-1:0] grant_idx;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      bank_flat[e*BW +: BW] = bnk[e];
      arr_flat[e*32 +: 32]  = arr[e];
      dl_flat[e*32 +: 32]   = dl[e];
    end
    for (int b = 0; b < NB; b++) cyc_flat[b*CW +: CW] = cyc[b];
  end

  fq_dram_arbiter #(.N(N), .NB(NB), .CW(CW), .TRAS(TRAS)) dut_i (
    .clk(clk), .rst_n(rst_n), .fq_mode(fq_mode),
    .ent_valid(vld), .ent_ready(rdy), .ent_col(col), .ent_bank(bank_flat),
    .ent_arrival(arr_flat), .ent_deadline(dl_flat),
    .bank_open(opn), .bank_open_cycles(cyc_flat),
    .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  task automatic chk(input string req, input bit exp_gv, input int exp_idx);
    tests++;
    if (grant_valid !== exp_gv || (exp_gv && grant_idx !== IW'(exp_idx))) begin
      fails++;
      $display("FAIL %s: got gv=%0b idx=%0d, expected gv=%0b idx=%0d",
               req, grant_valid, grant_idx, exp_gv, exp_idx);
    end
  endtask

  task automatic put(input int e, input bit r, input bit c, input int b,
                     input int a, input int d);
    vld[e] = 1; rdy[e] = r; col[e] = c; bnk[e] = BW'(b); arr[e] = a; dl[e] = d;
  endtask

  task automatic clear_all();
    @(negedge clk);
    vld = '0; rdy = '0; col = '0; opn = '0;
    for (int e = 0; e < N; e++) begin bnk[e] = '0; arr[e] = '0; dl[e] = '0; end
    for (int b = 0; b < NB; b++) cyc[b] = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    vld = '0; rdy = '0; col = '0; opn = '0;
    for (int e = 0; e < N; e++) begin bnk[e] = '0; arr[e] = '0; dl[e] = '0; end
    for (int b = 0; b < NB; b++) cyc[b] = '0;
    repeat (3) @(negedge clk);
    #1 chk("R1 reset idle", 0, 0);
    rst_n = 1;
  endtask

  task automatic t_none_ready();
    clear_all();
    put(4, 0, 1, 0, 1, 1); put(9, 0, 0, 1, 2, 2);
    #1 chk("R1 valid but not ready", 0, 0);
  endtask

  task automatic t_base_col();
    clear_all(); fq_mode = 0;
    put(3, 1, 0, 0, 1, 1); put(7, 1, 1, 1, 50, 90); put(9, 0, 1, 2, 0, 0);
    #1 chk("R2 column beats older row", 1, 7);
  endtask

  task automatic t_base_age();
    clear_all(); fq_mode = 0;
    put(4, 1, 1, 0, 20, 1); put(10, 1, 1, 1, 5, 99); put(12, 1, 1, 2, 5, 3);
    #1 chk("R3 oldest column, index tie", 1, 10);
    clear_all();
    put(2, 1, 0, 0, 9, 50); put(5, 1, 0, 1, 9, 1); put(8, 1, 0, 2, 30, 0);
    #1 chk("R3 oldest row, index tie", 1, 2);
  endtask

  task automatic t_fq_edf();
    clear_all(); fq_mode = 1;
    put(3, 1, 1, 0, 1, 100); put(6, 1, 0, 1, 90, 40); put(8, 1, 1, 2, 2, 40);
    #1 chk("R4 earliest deadline, index tie", 1, 6);
  endtask

  task automatic t_fq_young();
    clear_all(); fq_mode = 1;
    opn[2] = 1; cyc[2] = 5;
    put(1, 0, 1, 2, 0, 10); put(4, 1, 1, 2, 0, 50);
    #1 chk("R5 young bank first-ready", 1, 4);
    @(negedge clk); cyc[2] = TRAS - 1;
    #1 chk("R5 one short of lock", 1, 4);
  endtask

  task automatic t_fq_lock();
    clear_all(); fq_mode = 1;
    opn[2] = 1; cyc[2] = TRAS;
    put(1, 0, 1, 2, 0, 10); put(4, 1, 1, 2, 0, 50);
    #1 chk("R6 locked bank waits", 0, 0);
    put(11, 1, 1, 5, 0, 70);
    #1 chk("R6 other bank unaffected", 1, 11);
    @(negedge clk); rdy[1] = 1;
    #1 chk("R6 committed slot granted", 1, 1);
  endtask

  task automatic t_commit();
    clear_all(); fq_mode = 1;
    opn[3] = 1; cyc[3] = 30;
    put(2, 0, 1, 3, 0, 60); put(5, 1, 1, 3, 0, 80);
    #1 chk("R6 commit on earliest", 0, 0);
    @(negedge clk);
    put(9, 1, 1, 3, 0, 20);
    #1 chk("R7 commit kept over newer earlier deadline", 0, 0);
    @(negedge clk); rdy[2] = 1;
    #1 chk("R7 committed slot granted", 1, 2);
    @(negedge clk); vld[2] = 0;
    #1 chk("R7 next commitment after grant", 1, 9);
  endtask

  task automatic t_base_nolock();
    clear_all(); fq_mode = 0;
    opn[2] = 1; cyc[2] = 40;
    put(1, 0, 0, 2, 0, 10); put(4, 1, 1, 2, 5, 50);
    #1 chk("R8 baseline ignores open time", 1, 4);
  endtask

  task automatic t_release();
    clear_all(); fq_mode = 1;
    opn[3] = 1; cyc[3] = 30;
    put(2, 0, 1, 3, 0, 60);
    @(negedge clk);
    put(9, 0, 1, 3, 0, 20); put(5, 1, 1, 3, 0, 80);
    #1 chk("R7 held commit blocks", 0, 0);
    @(negedge clk); opn[3] = 0; cyc[3] = 0;
    #1 chk("R9 closed bank first-ready", 1, 5);
    @(negedge clk); vld[5] = 0; rdy[9] = 1; opn[3] = 1; cyc[3] = 30;
    #1 chk("R9 fresh commitment on relock", 1, 9);
  endtask

  initial begin
    t_reset();
    t_none_ready();
    t_base_col();
    t_base_age();
    t_fq_edf();
    t_fq_young();
    t_fq_lock();
    t_commit();
    t_base_nolock();
    t_release();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule